// File: doc/BRIEF.md
# Shared Interrupt Affinity Router

This block keeps the routing state of the shared peripheral interrupts. Each shared interrupt owns one 64-bit routing entry that software writes with a target CPU affinity. The block stores that affinity and returns it on reads exactly as it was written. It also checks the affinity against a CPU affinity table, which is a configuration input. The result is kept in two forms: a per-interrupt target index, and a one-hot per-CPU target bitmap that the delivery logic downstream consumes.

The routing window begins at the entry of the first shared interrupt, which is interrupt 32. That interrupt is local entry 0, and entry n sits at byte offset 8·n. A low-word write runs through a small state machine:

- **ST_IDLE**: waiting. The transition *accept* fires on a valid low-word write.
- **ST_LOOKUP**: the new affinity is stored. The old affinity and the new one are both matched against the CPU table, and the results are registered. The transition *matched* follows.
- **ST_COMMIT**: the interrupt's bit is cleared in the old CPU's map and set in the new CPU's map, and the index is written. The transition *committed* follows.
- **ST_NOTIFY**: the update pulse is raised for one cycle. The transition *notified* returns to ST_IDLE.

Top module: `aff_router`

## Requirements
- R1: After reset, the low word of every entry reads as bits [23:0] of CPU 0's table affinity, with bits [31:24] zero. Every target index is 0, and only CPU 0's map bit is set for every interrupt.
- R2: The entry of local interrupt n has its low word at byte offset 8·n and its upper word at 8·n+4. The upper word always reads 0. A write to it changes no state, raises no busy and raises no pulse.
- R3: A low-word read returns the last written bits [23:0], with bits [31:24] reading 0. This holds even when the affinity matches no CPU.
- R4: The lookup compares written bits [23:0] against bits [23:0] of every table entry in parallel. The lowest matching CPU index wins. Table bits [31:24] are ignored.
- R5: A routing write clears the interrupt's bit in the map of the CPU that matches the previously stored affinity. It then sets the bit for the newly matched CPU and records that CPU's index in the 8-bit target index.
- R6: When the new affinity matches no CPU, the target index becomes 8'hFF and no map bit is set for that interrupt.
- R7: For every interrupt, at most one CPU map bit is set. It is set exactly when the index is not 8'hFF, and it is the bit at that index.
- R8: An accepted low-word write keeps busy high for exactly 3 cycles. The update pulse is high for exactly one cycle, the third of those cycles. Writes presented while busy is high are ignored.
- R9: rvalid rises in the cycle after rd_en, carrying the read data.
- R10: The CPU count is limited to 1..255, so that code 8'hFF stays free for "not allocated".

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_aff_i | input | NUM_CPU*32 | CPU affinity table, CPU c in bits [32c+31:32c] |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W | Byte offset within the routing window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data |
| rvalid_o | output | 1 | Read data valid |
| busy_o | output | 1 | Routing update in progress |
| upd_pulse_o | output | 1 | One-cycle state-update pulse |
| tgt_map_o | output | NUM_CPU*NUM_SPI | Target maps, bit c*NUM_SPI+n is set when interrupt n targets CPU c |
| tgt_idx_o | output | NUM_SPI*8 | Target index of interrupt n in bits [8n+7:8n] |

## Verification
The bench moves every interrupt through every CPU and through an unmatched affinity, and checks all maps and indices after each write. A design that forgot the old-map clear would leave two bits set in one column, and one that matched on table bits [31:24] would miss a CPU whose top byte differs. Two table entries share the same low 24 bits to catch a design that lets the last match win instead of the first. Upper-word writes and writes made while busy must leave reads, maps and indices unchanged. A design that decoded the upper word as a routing write, or that queued the second write, would alter one of them.

// File: rtl/aff_route_pkg.sv
package aff_route_pkg;
    localparam int AFF_W   = 32;
    localparam int HWID_W  = 24;
    localparam int IDX_W   = 8;
    localparam logic [IDX_W-1:0] IDX_NONE = 8'hFF;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_COMMIT,
        ST_NOTIFY
    } route_state_t;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } match_t;

    // Keep only the affinity levels this block routes on.
    function automatic logic [AFF_W-1:0] trim_aff(input logic [AFF_W-1:0] raw);
        return {{(AFF_W-HWID_W){1'b0}}, raw[HWID_W-1:0]};
    endfunction
endpackage

// File: rtl/aff_match.sv
module aff_match
    import aff_route_pkg::*;
#(
    parameter int NUM_CPU = 8
) (
    input  logic [NUM_CPU*AFF_W-1:0] table_i,
    input  logic [AFF_W-1:0]         key_i,
    output match_t                   res_o
);
    logic [NUM_CPU-1:0] hit;

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cmp
        assign hit[c] = (table_i[c*AFF_W +: HWID_W] == key_i[HWID_W-1:0]);
    end

    // Walk downward so the lowest matching index is the one left.
    always_comb begin
        res_o.hit = 1'b0;
        res_o.idx = IDX_NONE;
        for (int c = NUM_CPU-1; c >= 0; c--) begin
            if (hit[c]) begin
                res_o.hit = 1'b1;
                res_o.idx = IDX_W'(c);
            end
        end
    end
endmodule

// File: rtl/aff_route_ctrl.sv
module aff_route_ctrl
    import aff_route_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_go_i,
    output route_state_t state_o,
    output logic         capture_o,
    output logic         busy_o,
    output logic         pulse_o
);
    route_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (wr_go_i) state_d = ST_LOOKUP;   // accept
            ST_LOOKUP: state_d = ST_COMMIT;                // matched
            ST_COMMIT: state_d = ST_NOTIFY;                // committed
            ST_NOTIFY: state_d = ST_IDLE;                  // notified
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        capture_o = 1'b0;
        busy_o    = 1'b1;
        pulse_o   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy_o    = 1'b0;
                capture_o = wr_go_i;
            end
            ST_LOOKUP: ;
            ST_COMMIT: ;
            ST_NOTIFY: pulse_o = 1'b1;
            default:   busy_o = 1'b0;
        endcase
    end

    assign state_o = state_q;

    p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && wr_go_i) |=> (state_q == ST_LOOKUP));
    p_lookup_then_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOKUP) |=> (state_q == ST_COMMIT));
    p_pulse_after_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |-> ($past(state_q) == ST_COMMIT));
    p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o);
endmodule

// File: rtl/aff_route_store.sv
module aff_route_store
    import aff_route_pkg::*;
#(
    parameter int NUM_SPI = 32,
    parameter int NUM_CPU = 8,
    parameter int SPI_W   = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CPU*AFF_W-1:0] cpu_aff_i,
    input  route_state_t             state_i,
    input  logic                     capture_i,
    input  logic [SPI_W-1:0]         wr_spi_i,
    input  logic [AFF_W-1:0]         wdata_i,
    input  logic                     rd_en_i,
    input  logic                     rd_hit_i,
    input  logic [SPI_W-1:0]         rd_spi_i,
    output logic                     rvalid_o,
    output logic [AFF_W-1:0]         rdata_o,
    output logic [NUM_CPU*NUM_SPI-1:0] map_o,
    output logic [NUM_SPI*IDX_W-1:0]   idx_o
);
    logic [AFF_W-1:0]   aff_q [NUM_SPI];
    logic [IDX_W-1:0]   idx_q [NUM_SPI];
    logic [NUM_SPI-1:0] map_q [NUM_CPU];
    logic [SPI_W-1:0]   spi_q;
    logic [AFF_W-1:0]   data_q;
    match_t             old_res, new_res, old_q, new_q;
    logic               rvalid_q;
    logic [AFF_W-1:0]   rdata_q;

    aff_match #(.NUM_CPU(NUM_CPU)) u_old_match (
        .table_i(cpu_aff_i), .key_i(aff_q[spi_q]), .res_o(old_res));
    aff_match #(.NUM_CPU(NUM_CPU)) u_new_match (
        .table_i(cpu_aff_i), .key_i(data_q), .res_o(new_res));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spi_q  <= '0;
            data_q <= '0;
            old_q  <= '0;
            new_q  <= '0;
        end else begin
            if (capture_i) begin
                spi_q  <= wr_spi_i;
                data_q <= trim_aff(wdata_i);
            end
            if (state_i == ST_LOOKUP) begin
                old_q <= old_res;
                new_q <= new_res;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SPI; s++) begin
                aff_q[s] <= trim_aff(cpu_aff_i[AFF_W-1:0]);
                idx_q[s] <= '0;
            end
        end else begin
            if (state_i == ST_LOOKUP) aff_q[spi_q] <= data_q;
            if (state_i == ST_COMMIT) idx_q[spi_q] <= new_q.idx;
        end
    end

    // Clear before set: when the old and new CPU are the same, the set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NUM_CPU; c++) map_q[c] <= (c == 0) ? '1 : '0;
        end else if (state_i == ST_COMMIT) begin
            for (int c = 0; c < NUM_CPU; c++) begin
                if (old_q.hit && old_q.idx == IDX_W'(c)) map_q[c][spi_q] <= 1'b0;
                if (new_q.hit && new_q.idx == IDX_W'(c)) map_q[c][spi_q] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
        end else begin
            rvalid_q <= rd_en_i;
            rdata_q  <= (rd_en_i && rd_hit_i) ? aff_q[rd_spi_i] : '0;
        end
    end

    assign rvalid_o = rvalid_q;
    assign rdata_o  = rdata_q;

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_map_out
        assign map_o[c*NUM_SPI +: NUM_SPI] = map_q[c];
    end

    for (genvar s = 0; s < NUM_SPI; s++) begin : g_spi
        logic [NUM_CPU-1:0] col;
        for (genvar c = 0; c < NUM_CPU; c++) begin : g_col
            assign col[c] = map_q[c][s];
        end
        assign idx_o[s*IDX_W +: IDX_W] = idx_q[s];

        p_single_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(col));
        p_none_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (idx_q[s] == IDX_NONE) |-> (col == '0));
        p_index_has_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (idx_q[s] != IDX_NONE) |-> ($countones(col) == 1));
    end

    p_read_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_i |=> rvalid_q);
    p_miss_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid_q && !$past(rd_hit_i)) |-> (rdata_q == '0));
    p_top_byte_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid_q |-> (rdata_q[AFF_W-1:HWID_W] == '0));
endmodule

// File: rtl/aff_router.sv
module aff_router
    import aff_route_pkg::*;
#(
    parameter int NUM_SPI = 32,
    parameter int NUM_CPU = 8,
    parameter int ADDR_W  = $clog2(NUM_SPI) + 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_CPU*32-1:0]      cpu_aff_i,
    input  logic                       wr_en_i,
    input  logic                       rd_en_i,
    input  logic [ADDR_W-1:0]          addr_i,
    input  logic [31:0]                wdata_i,
    output logic [31:0]                rdata_o,
    output logic                       rvalid_o,
    output logic                       busy_o,
    output logic                       upd_pulse_o,
    output logic [NUM_CPU*NUM_SPI-1:0] tgt_map_o,
    output logic [NUM_SPI*8-1:0]       tgt_idx_o
);
    localparam int SPI_W = ADDR_W - 3;

    logic [SPI_W-1:0] entry;
    logic             in_range, low_word, wr_go, rd_hit, capture;
    route_state_t     state;

    initial begin
        p_cpu_count_r10: assert (NUM_CPU >= 1 && NUM_CPU <= 255);
    end

    assign entry    = addr_i[ADDR_W-1:3];
    assign in_range = (int'(entry) < NUM_SPI);
    assign low_word = !addr_i[2];
    assign wr_go    = wr_en_i && low_word && in_range;
    assign rd_hit   = low_word && in_range;

    aff_route_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_go_i(wr_go), .state_o(state),
        .capture_o(capture), .busy_o(busy_o), .pulse_o(upd_pulse_o));

    aff_route_store #(.NUM_SPI(NUM_SPI), .NUM_CPU(NUM_CPU), .SPI_W(SPI_W)) u_store (
        .clk(clk), .rst_n(rst_n), .cpu_aff_i(cpu_aff_i), .state_i(state),
        .capture_i(capture), .wr_spi_i(entry), .wdata_i(wdata_i),
        .rd_en_i(rd_en_i), .rd_hit_i(rd_hit), .rd_spi_i(entry),
        .rvalid_o(rvalid_o), .rdata_o(rdata_o), .map_o(tgt_map_o), .idx_o(tgt_idx_o));

    p_hi_write_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && wr_en_i && !low_word) |=> !busy_o);
endmodule

// File: tb/aff_router_test.sv
module aff_router_test;
    localparam int NS = 8;
    localparam int NC = 4;
    localparam int AW = 6;

    logic              clk = 0;
    logic              rst_n = 0;
    logic [NC*32-1:0]  cpu_aff;
    logic              wr_en = 0, rd_en = 0;
    logic [AW-1:0]     addr = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;
    logic              rvalid, busy, pulse;
    logic [NC*NS-1:0]  tmap;
    logic [NS*8-1:0]   tidx;

    int total = 0, bad = 0, cyc = 0;
    logic [23:0] exp_aff [NS];
    logic [7:0]  exp_idx [NS];

    always #2.5 clk = ~clk;

    aff_router #(.NUM_SPI(NS), .NUM_CPU(NC), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .cpu_aff_i(cpu_aff), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid),
        .busy_o(busy), .upd_pulse_o(pulse), .tgt_map_o(tmap), .tgt_idx_o(tidx));

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++; total++;
            $display("FAIL watchdog act=%0d exp=<150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] lookup(input logic [31:0] v);
        for (int c = 0; c < NC; c++)
            if (cpu_aff[c*32 +: 24] == v[23:0]) return 8'(c);
        return 8'hFF;
    endfunction

    task automatic rd(input int n, input bit hi, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1; addr = AW'(n*8 + (hi ? 4 : 0));
        @(negedge clk);
        rd_en = 0;
        chk(rvalid === 1'b1, "R9 rvalid", 32'(rvalid), 1);
        d = rdata;
    endtask

    task automatic check_all(input string tag);
        logic [31:0] d;
        for (int s = 0; s < NS; s++) begin
            chk(tidx[s*8 +: 8] === exp_idx[s], {tag, " idx R5/R6"}, 32'(tidx[s*8 +: 8]), 32'(exp_idx[s]));
            for (int c = 0; c < NC; c++)
                chk(tmap[c*NS + s] === (exp_idx[s] == 8'(c)), {tag, " map R7"},
                    32'(tmap[c*NS + s]), 32'(exp_idx[s] == 8'(c)));
            rd(s, 0, d);
            chk(d === {8'h00, exp_aff[s]}, {tag, " read R3"}, d, {8'h00, exp_aff[s]});
        end
    endtask

    task automatic wr_low(input int n, input logic [31:0] v, input bit extra);
        int nb = 0, np = 0;
        @(negedge clk);
        wr_en = 1; addr = AW'(n*8); wdata = v;
        @(negedge clk);
        if (extra) begin
            addr = AW'(((n + 1) % NS) * 8); wdata = 32'h00_0102_00;
        end else wr_en = 0;
        while (busy && nb < 10) begin
            if (pulse) np++;
            nb++;
            @(negedge clk);
            wr_en = 0;
        end
        wr_en = 0;
        chk(nb == 3, "R8 busy cycles", 32'(nb), 3);
        chk(np == 1, "R8 pulse count", 32'(np), 1);
        exp_aff[n] = v[23:0];
        exp_idx[n] = lookup(v);
    endtask

    initial begin
        logic [31:0] d;
        logic [31:0] vals [5];
        for (int c = 0; c < 3; c++) cpu_aff[c*32 +: 32] = {8'h5A, 16'h0102, 8'(c*2)};
        cpu_aff[3*32 +: 32] = {8'h77, 16'h0102, 8'h02};   // same low bits as CPU 1
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset routing
        for (int s = 0; s < NS; s++) begin
            exp_aff[s] = cpu_aff[23:0];
            exp_idx[s] = 8'h00;
        end
        chk(busy === 1'b0, "R1 busy idle", 32'(busy), 0);
        check_all("R1 reset");

        // R4/R5/R6 sweep: every interrupt through every target and an unmatched one
        vals[0] = 32'h00_0102_02;   // CPU 1 (first of two matches, R4)
        vals[1] = 32'hFF_0102_04;   // CPU 2, top byte ignored (R3, R4)
        vals[2] = 32'h00_0305_07;   // no CPU (R6)
        vals[3] = 32'h00_0102_00;   // CPU 0
        vals[4] = 32'h00_0102_04;   // CPU 2
        for (int s = 0; s < NS; s++) begin
            for (int k = 0; k < 5; k++) begin
                wr_low(s, vals[(k + s) % 5], 0);
                check_all("R4 sweep");
            end
        end

        // R2: upper word reads zero and ignores writes
        @(negedge clk);
        wr_en = 1; addr = AW'(3*8 + 4); wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        wr_en = 0;
        chk(busy === 1'b0, "R2 hi write busy", 32'(busy), 0);
        chk(pulse === 1'b0, "R2 hi write pulse", 32'(pulse), 0);
        rd(3, 1, d);
        chk(d === 32'h0, "R2 hi read", d, 0);
        check_all("R2 after hi write");

        // R8: a write issued while busy is dropped
        wr_low(5, 32'h00_0305_09, 1);
        check_all("R8 busy write");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule